// File: doc/BRIEF.md
# Multicast Setup Packet Retyping Stage

This block sits in a router input path, just after route computation, and looks at one flit per cycle. A multicast tree is built in two phases. In the first phase a setup packet travels like a unicast packet towards a chosen branch node. Its header routing fields count down the remaining X and Y hops. When both hop counts reach zero, the packet has arrived at the branch node. The stage then turns it into a second-phase setup packet, which travels on to the real destination and writes the table entries along its way.

The retyping takes the second leg's routing block from the front of the payload. The source node computed that block in advance: the direction bits, the hop counts and the output port for the next router. The stage copies it into the header and does no routing work of its own, so the copied output port is forwarded exactly as it was written. Every other flit goes through bit for bit. The result is registered, which gives a fixed latency of one cycle.

Flit layout, most significant field first: flit type (2 bits), packet type (3 bits), routing block (xdir 1, ydir 1, X hops DIST_W, Y hops DIST_W, output port PORT_W), source id (SRC_W), table index (TIDX_W), set/clear flag (1), payload (PAY_W). The routing block is RT_W = 2 + 2·DIST_W + PORT_W bits wide, which is 11 with the defaults.

Top module: `mcs_setup_retype`

## Requirements
- R1: A synchronous active-high `rst` drives `out_valid` to 0 and `out_flit` to all zeros on the next clock edge, whatever the inputs are.
- R2: `out_valid` equals `in_valid` one cycle earlier, so each accepted flit appears exactly once, one cycle after it is presented.
- R3: A valid flit is converted when all of the following hold: its flit type is head (2'b00) or single-flit (2'b01), its packet type is first-phase setup (3'b001), and both its X hop field and its Y hop field are zero. A converted flit leaves with packet type 3'b010, the second-phase setup.
- R4: On conversion, the routing block is replaced by the top RT_W payload bits, taken in the same order from the MSB (xdir, ydir, X hops, Y hops, output port). The output port value is copied verbatim.
- R5: On conversion, the flit type, source id, table index, set/clear flag and the entire payload leave unchanged.
- R6: A first-phase setup head flit with a nonzero X hop field or a nonzero Y hop field passes unchanged.
- R7: Body (2'b10) and tail (2'b11) flits pass unchanged, even when they carry packet type 3'b001 and zero hop fields.
- R8: Packet types other than 3'b001 (unicast 000, second-phase setup 010, setup reply 011, clear 100, clear reply 101, multicast data 110, reserved 111) pass unchanged.
- R9: While `in_valid` is low, `out_flit` holds its previous value, and the input data has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit qualifier |
| in_flit | input | FLIT_W (41) | Flit from route computation |
| out_valid | output | 1 | Registered output qualifier |
| out_flit | output | FLIT_W (41) | Registered, possibly retyped flit |

## Verification
The hardest case is a flit that satisfies all but one of the conversion conditions. Examples are a body or tail flit that carries the first-phase type with zero hop counts, or a head flit with exactly one nonzero hop field. Random traffic seldom produces these, so the bench drives each such near-miss on purpose, right next to true conversions. It also sends payloads of all zeros and all ones, so that misordered or stuck copied bits show up in the output. Idle cycles carry random junk data, which shows whether the output register leaks input data while `in_valid` is low.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int FT_W = 2;
  localparam int PT_W = 3;

  typedef enum logic [FT_W-1:0] {
    FT_HEAD = 2'b00,
    FT_SOLO = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } ftype_e;

  typedef enum logic [PT_W-1:0] {
    PT_UNICAST   = 3'b000,
    PT_SETUP_A   = 3'b001,
    PT_SETUP_B   = 3'b010,
    PT_SETUP_ACK = 3'b011,
    PT_CLEAR     = 3'b100,
    PT_CLEAR_ACK = 3'b101,
    PT_DATA      = 3'b110,
    PT_RSVD      = 3'b111
  } ptype_e;

  // head or single-flit: the flits that open a packet
  function automatic logic is_leading(input logic [FT_W-1:0] ft);
    return (ft == FT_HEAD) || (ft == FT_SOLO);
  endfunction

endpackage

// File: rtl/mcs_conv_detect.sv
module mcs_conv_detect
  import mcs_pkg::*;
#(
  parameter int DIST_W = 3
) (
  input  logic              valid,
  input  logic [FT_W-1:0]   ftype,
  input  logic [PT_W-1:0]   ptype,
  input  logic [DIST_W-1:0] xdist,
  input  logic [DIST_W-1:0] ydist,
  output logic              convert
);

  logic arrived;
  logic first_phase;

  always_comb begin
    arrived     = ~|{xdist, ydist};
    first_phase = (ptype == PT_SETUP_A);
    convert     = valid && is_leading(ftype) && first_phase && arrived;
  end

endmodule

// File: rtl/mcs_route_splice.sv
module mcs_route_splice
  import mcs_pkg::*;
#(
  parameter int FLIT_W = 41,
  parameter int RT_LSB = 25,
  parameter int RT_W   = 11,
  parameter int PT_LSB = 36
) (
  input  logic [FLIT_W-1:0] flit_in,
  input  logic              convert,
  input  logic [RT_W-1:0]   route_new,
  output logic [FLIT_W-1:0] flit_out
);

  always_comb begin
    flit_out = flit_in;
    if (convert) begin
      flit_out[PT_LSB +: PT_W] = PT_SETUP_B;
      flit_out[RT_LSB +: RT_W] = route_new;
    end
  end

endmodule

// File: rtl/mcs_out_stage.sv
module mcs_out_stage #(
  parameter int W = 41
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q <= d;
    end
  end

endmodule

// File: rtl/mcs_setup_retype.sv
module mcs_setup_retype
  import mcs_pkg::*;
#(
  parameter int DIST_W = 3,
  parameter int PORT_W = 3,
  parameter int SRC_W  = 4,
  parameter int TIDX_W = 4,
  parameter int PAY_W  = 16,
  localparam int RT_W     = 2 + 2 * DIST_W + PORT_W,
  localparam int SC_POS   = PAY_W,
  localparam int TIDX_LSB = SC_POS + 1,
  localparam int SRC_LSB  = TIDX_LSB + TIDX_W,
  localparam int RT_LSB   = SRC_LSB + SRC_W,
  localparam int PT_LSB   = RT_LSB + RT_W,
  localparam int FT_LSB   = PT_LSB + PT_W,
  localparam int FLIT_W   = FT_LSB + FT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit
);

  // position of the hop counts inside the routing block
  localparam int YD_LSB = RT_LSB + PORT_W;
  localparam int XD_LSB = YD_LSB + DIST_W;

  generate
    if (PAY_W < RT_W) begin : g_bad_cfg
      $error("payload narrower than the routing block");
    end
  endgenerate

  logic              convert;
  logic [RT_W-1:0]   route_new;
  logic [FLIT_W-1:0] flit_next;

  assign route_new = in_flit[PAY_W-1 -: RT_W];

  mcs_conv_detect #(.DIST_W(DIST_W)) u_detect (
    .valid   (in_valid),
    .ftype   (in_flit[FT_LSB +: FT_W]),
    .ptype   (in_flit[PT_LSB +: PT_W]),
    .xdist   (in_flit[XD_LSB +: DIST_W]),
    .ydist   (in_flit[YD_LSB +: DIST_W]),
    .convert (convert)
  );

  mcs_route_splice #(
    .FLIT_W (FLIT_W),
    .RT_LSB (RT_LSB),
    .RT_W   (RT_W),
    .PT_LSB (PT_LSB)
  ) u_splice (
    .flit_in   (in_flit),
    .convert   (convert),
    .route_new (route_new),
    .flit_out  (flit_next)
  );

  mcs_out_stage #(.W(FLIT_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       (flit_next),
    .q_valid (out_valid),
    .q       (out_flit)
  );

endmodule

// File: rtl/mcs_setup_retype_chk.sv
module mcs_setup_retype_chk #(
  parameter int DIST_W = 3,
  parameter int PORT_W = 3,
  parameter int SRC_W  = 4,
  parameter int TIDX_W = 4,
  parameter int PAY_W  = 16,
  localparam int RT_W   = 2 + 2 * DIST_W + PORT_W,
  localparam int RT_LSB = PAY_W + 1 + TIDX_W + SRC_W,
  localparam int PT_LSB = RT_LSB + RT_W,
  localparam int FT_LSB = PT_LSB + 3,
  localparam int FLIT_W = FT_LSB + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FLIT_W-1:0] in_flit,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_flit
);

  localparam int YD_LSB = RT_LSB + PORT_W;
  localparam int XD_LSB = YD_LSB + DIST_W;
  localparam logic [FLIT_W-1:0] RT_MASK = {{(FLIT_W-RT_W){1'b0}}, {RT_W{1'b1}}} << RT_LSB;
  localparam logic [FLIT_W-1:0] PT_MASK = {{(FLIT_W-3){1'b0}}, 3'b111} << PT_LSB;
  localparam logic [FLIT_W-1:0] KEEP    = ~(RT_MASK | PT_MASK);

  logic hit;
  always_comb begin
    hit = in_valid
       && (in_flit[FT_LSB+1] == 1'b0)
       && (in_flit[PT_LSB +: 3] == 3'b001)
       && (in_flit[XD_LSB +: DIST_W] == '0)
       && (in_flit[YD_LSB +: DIST_W] == '0);
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_flit == '0));

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R3
  a_r3_retype: assert property (@(posedge clk) disable iff (rst)
    hit |=> (out_flit[PT_LSB +: 3] == 3'b010));

  // R4
  a_r4_route_copy: assert property (@(posedge clk) disable iff (rst)
    hit |=> (out_flit[RT_LSB +: RT_W] == $past(in_flit[PAY_W-1 -: RT_W])));

  // R5
  a_r5_fields_kept: assert property (@(posedge clk) disable iff (rst)
    hit |=> ((out_flit & KEEP) == ($past(in_flit) & KEEP)));

  // R6 R7 R8
  a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hit) |=> (out_flit == $past(in_flit)));

  // R9
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_flit));

endmodule

bind mcs_setup_retype mcs_setup_retype_chk #(
  .DIST_W (DIST_W),
  .PORT_W (PORT_W),
  .SRC_W  (SRC_W),
  .TIDX_W (TIDX_W),
  .PAY_W  (PAY_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_flit   (in_flit),
  .out_valid (out_valid),
  .out_flit  (out_flit)
);

// File: tb/test_mcs_setup_retype.sv
`timescale 1ns/1ps
module test_mcs_setup_retype;

  localparam int FW = 41;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_flit = '0;
  logic          out_valid;
  logic [FW-1:0] out_flit;

  always #2 clk = ~clk;

  mcs_setup_retype i_mcs_setup_retype (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_flit   (in_flit),
    .out_valid (out_valid),
    .out_flit  (out_flit)
  );

  typedef struct {
    logic [FW-1:0] exp;
    string         req;
  } item_t;

  item_t         sb[$];
  int            checks = 0;
  int            errors = 0;
  logic [FW-1:0] held = '0;
  logic          exp_v = 1'b0;
  logic          mon_on = 1'b0;

  function automatic logic [FW-1:0] mk(
    input logic [1:0] ft, input logic [2:0] pt, input logic xd, input logic yd,
    input logic [2:0] xs, input logic [2:0] ys, input logic [2:0] op,
    input logic [3:0] src, input logic [3:0] tix, input logic sc, input logic [15:0] pay);
    return {ft, pt, xd, yd, xs, ys, op, src, tix, sc, pay};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: presents one flit and queues what the requirements predict
  task automatic send(input logic [1:0] ft, input logic [2:0] pt, input logic xd,
                      input logic yd, input logic [2:0] xs, input logic [2:0] ys,
                      input logic [2:0] op, input logic [3:0] src, input logic [3:0] tix,
                      input logic sc, input logic [15:0] pay, input string req);
    logic [FW-1:0] f, e;
    f = mk(ft, pt, xd, yd, xs, ys, op, src, tix, sc, pay);
    if (ft inside {2'b00, 2'b01} && pt == 3'b001 && xs == 3'd0 && ys == 3'd0)
      e = mk(ft, 3'b010, pay[15], pay[14], pay[13:11], pay[10:8], pay[7:5],
             src, tix, sc, pay);
    else
      e = f;
    @(negedge clk);
    in_valid = 1'b1;
    in_flit  = f;
    sb.push_back('{exp: e, req: req});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_flit  = {$urandom, $urandom};
    end
  endtask

  always @(posedge clk) exp_v <= in_valid && !rst;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      check(out_valid == exp_v, "R2 valid timing", {40'd0, out_valid}, {40'd0, exp_v});
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 output without input", out_flit, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(out_flit == it.exp, it.req, out_flit, it.exp);
          held = it.exp;
        end
      end else begin
        check(out_flit == held, "R9 hold while idle", out_flit, held);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset held with busy input
    in_valid = 1'b1;
    in_flit  = {$urandom, $urandom};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R1 reset valid", {40'd0, out_valid}, '0);
    check(out_flit == '0, "R1 reset data", out_flit, '0);
    mon_on = 1'b1;

    // conversions at the branch node
    for (int i = 0; i < 16; i++) begin
      send(i[0] ? 2'b01 : 2'b00, 3'b001, 1'($urandom), 1'($urandom), 3'd0, 3'd0,
           3'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 16'($urandom),
           "R3 R4 R5 conversion");
      if (i % 5 == 4) idle(2);
    end
    send(2'b00, 3'b001, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 4'hF, 4'hF, 1'b1, 16'hFFFF,
         "R4 all-ones payload");
    send(2'b01, 3'b001, 1'b1, 1'b1, 3'd0, 3'd0, 3'd7, 4'h0, 4'h0, 1'b0, 16'h0000,
         "R4 all-zero payload");
    send(2'b00, 3'b001, 1'b0, 1'b1, 3'd0, 3'd0, 3'd2, 4'h5, 4'hA, 1'b0, 16'b1010_1100_1110_0001,
         "R4 R5 field order");
    idle(3);

    // near misses
    for (int d = 1; d < 8; d++) begin
      send(2'b00, 3'b001, 1'b0, 1'b1, 3'(d), 3'd0, 3'($urandom), 4'($urandom),
           4'($urandom), 1'($urandom), 16'($urandom), "R6 x hops nonzero");
      send(2'b01, 3'b001, 1'b1, 1'b0, 3'd0, 3'(d), 3'($urandom), 4'($urandom),
           4'($urandom), 1'($urandom), 16'($urandom), "R6 y hops nonzero");
    end
    send(2'b00, 3'b001, 1'b1, 1'b1, 3'd7, 3'd7, 3'd1, 4'd3, 4'd9, 1'b1, 16'hBEEF,
         "R6 both hops nonzero");
    send(2'b10, 3'b001, 1'b0, 1'b0, 3'd0, 3'd0, 3'd4, 4'd1, 4'd2, 1'b0, 16'hFFFF,
         "R7 body flit");
    send(2'b11, 3'b001, 1'b1, 1'b0, 3'd0, 3'd0, 3'd5, 4'd7, 4'd8, 1'b1, 16'hA5A5,
         "R7 tail flit");
    idle(1);
    for (int p = 0; p < 8; p++) begin
      if (p != 1)
        send(p[0] ? 2'b01 : 2'b00, 3'(p), 1'b0, 1'b0, 3'd0, 3'd0, 3'($urandom),
             4'($urandom), 4'($urandom), 1'($urandom), 16'($urandom), "R8 other packet type");
    end
    idle(4);

    // mixed traffic biased towards the conversion corner
    for (int i = 0; i < 300; i++) begin
      logic [2:0] pt;
      pt = ($urandom % 2) ? 3'b001 : 3'($urandom);
      send(2'($urandom), pt, 1'($urandom), 1'($urandom),
           ($urandom % 2) ? 3'd0 : 3'($urandom), ($urandom % 2) ? 3'd0 : 3'($urandom),
           3'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 16'($urandom),
           "R3 R6 R7 R8 mixed");
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    check(sb.size() == 0, "R2 all flits delivered", FW'(sb.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule